// File: doc/BRIEF.md
# Overhead-Channel LAPD Frame Transmitter

This block sends one HDLC-style message frame at a time over a slow data-link channel. That channel is one overhead bit per outbound line frame. A host fills a byte buffer through a small register port, sets a message length, and sets a start bit. The block finishes the flag that is already going out, which then serves as the opening flag. It sends the message bytes least significant bit first, then a 16-bit frame check sequence, and then a closing flag. Zero-bit stuffing is applied to the message and the check sequence. Between frames the channel carries back-to-back idle flags.

The line framer raises `ovh_slot` for one clock in each outbound frame, at the moment the overhead bit must be supplied. Each such strobe moves the block forward by exactly one bit. In the time between strobes the block holds its state. When the closing flag has gone out, a status bit is set. That status bit reaches the interrupt pin only when both a per-source enable and a block-level transmit enable are set. Reading the control register clears the status bit.

Top module: `lapd_ovh_tx`

## Requirements
- R1: After reset, the block-enable register (0x04), the length register (0x33) and the control register (0x34) all read 0, `irq` is low and the block is idle.
- R2: While no frame is in progress, `ovh_bit` carries repeated 0x7E flags, bit 0 first (0,1,1,1,1,1,1,0). `ovh_bit` changes only at a clock edge where `ovh_slot` is high, and then takes the next bit.
- R3: After a start, the flag in progress is completed and serves as the opening flag. Then the message bytes follow in buffer order, each bit 0 first, then the 16-bit check sequence, then one closing 0x7E flag, after which idle flags resume.
- R4: The check sequence is a reflected CRC with polynomial 0x8408, preset to 0xFFFF and run over the message bits. It is sent complemented, bit 0 first. A length of 0 sends the check sequence alone (16 zeros).
- R5: After any five consecutive 1 bits taken from the message or the check sequence, a 0 bit is inserted. This includes the case just before the closing flag. Flag bits are never stuffed and do not count toward the run.
- R6: The length register at 0x33 stores 7 bits. A value above the 88-byte buffer depth sends 88 bytes.
- R7: Control register 0x34 layout: bit 3 = start, bit 2 = busy, bit 1 = source interrupt enable, bit 0 = completion status. Bits 7..4 read 0, and writes to bits 2 and 0 have no effect. Start reads 1 from its write until the frame is taken up at the flag boundary, and then clears itself.
- R8: Busy reads 1 from the start write until the clock edge that sends the last bit of the closing flag, and then reads 0.
- R9: A start written while busy is 1 is ignored: no further frame follows.
- R10: Status is set when the closing flag completes. A read of 0x34 returns status and clears it. If the read falls in the completion cycle, the read returns 0 in bit 0 and status still ends up set.
- R11: Register 0x04 keeps bits 7, 1 and 0, and its other bits read 0. `irq` is high exactly while status, the source enable (0x34 bit 1) and the transmit enable (0x04 bit 1) are all 1.
- R12: The message buffer spans 0x86..0xDD (88 bytes) and can be read and written. The byte at 0x86+k is the k-th byte sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status on 0x34) |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| ovh_slot | input | 1 | One-clock strobe for the overhead-bit slot |
| ovh_bit | output | 1 | Serial bit for the current overhead slot |
| irq | output | 1 | Active-high level interrupt |

## Verification
Completion and the clear-on-read of the control register can land on the same clock edge. In that case the set has to win, or the interrupt is lost. The bench provokes this by asserting a control-register read together with the strobe that carries the last closing-flag bit. It checks that this read returns busy 1 and status 0, and that the next read returns status 1 and busy 0. A second pairing is covered as well: a start written in the middle of a frame, while the serializer is already running. This case is judged by the absence of any further frame afterwards.

// File: rtl/lapd_tx_pkg.sv
package lapd_tx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_BODY  = 2'd1,
      ST_FCS   = 2'd2,
      ST_CLOSE = 2'd3
   } ser_state_e;

   localparam logic [7:0]  FLAG_BYTE  = 8'h7E;
   localparam logic [15:0] CRC_POLY_R = 16'h8408;
   localparam logic [15:0] CRC_PRESET = 16'hFFFF;
   localparam int          STUFF_RUN  = 5;

   // one bit of the reflected CRC-16 (x^16+x^12+x^5+1)
   function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
      logic fb;
      fb = c[0] ^ b;
      return (c >> 1) ^ (fb ? CRC_POLY_R : 16'h0000);
   endfunction

endpackage

// File: rtl/lapd_tx_ser.sv
module lapd_tx_ser
   import lapd_tx_pkg::*;
#(
   parameter int IDX_W = 7,
   parameter int LEN_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slot,
   input  logic             go,
   input  logic [LEN_W-1:0] len,
   input  logic [7:0]       byte_in,
   output logic [IDX_W-1:0] byte_idx,
   output logic             accept,
   output logic             done,
   output logic             active,
   output logic             tx_bit
);

   ser_state_e       state;
   logic [3:0]       bit_idx;
   logic [IDX_W-1:0] byte_q;
   logic [2:0]       ones;
   logic [15:0]      crc_q;
   logic [LEN_W-1:0] len_q;
   logic             tx_q;

   logic             stuff;
   logic             body_bit;
   logic             last_byte;
   logic [LEN_W:0]   next_cnt;

   always_comb begin
      stuff     = (state != ST_IDLE) && (ones == 3'(STUFF_RUN));
      body_bit  = (state == ST_BODY) ? byte_in[bit_idx[2:0]] : ~crc_q[bit_idx];
      next_cnt  = (LEN_W+1)'(byte_q) + (LEN_W+1)'(1);
      last_byte = (next_cnt == {1'b0, len_q});
      accept    = slot && (state == ST_IDLE) && (bit_idx == 4'd7) && go;
      done      = slot && (state == ST_CLOSE) && (bit_idx == 4'd7) && !stuff;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         bit_idx <= '0;
         byte_q  <= '0;
         ones    <= '0;
         crc_q   <= CRC_PRESET;
         len_q   <= '0;
         tx_q    <= 1'b0;
      end else if (slot) begin
         if (stuff) begin
            tx_q <= 1'b0;
            ones <= '0;
         end else begin
            unique case (state)
               ST_IDLE: begin
                  tx_q <= FLAG_BYTE[bit_idx[2:0]];
                  if (bit_idx == 4'd7) begin
                     bit_idx <= '0;
                     if (go) begin
                        len_q  <= len;
                        byte_q <= '0;
                        crc_q  <= CRC_PRESET;
                        ones   <= '0;
                        state  <= (len == '0) ? ST_FCS : ST_BODY;
                     end
                  end else begin
                     bit_idx <= bit_idx + 4'd1;
                  end
               end
               ST_BODY: begin
                  tx_q  <= body_bit;
                  crc_q <= crc_step(crc_q, body_bit);
                  ones  <= body_bit ? ones + 3'd1 : 3'd0;
                  if (bit_idx == 4'd7) begin
                     bit_idx <= '0;
                     if (last_byte) state  <= ST_FCS;
                     else           byte_q <= byte_q + IDX_W'(1);
                  end else begin
                     bit_idx <= bit_idx + 4'd1;
                  end
               end
               ST_FCS: begin
                  tx_q <= body_bit;
                  ones <= body_bit ? ones + 3'd1 : 3'd0;
                  if (bit_idx == 4'd15) begin
                     bit_idx <= '0;
                     state   <= ST_CLOSE;
                  end else begin
                     bit_idx <= bit_idx + 4'd1;
                  end
               end
               ST_CLOSE: begin
                  tx_q <= FLAG_BYTE[bit_idx[2:0]];
                  if (bit_idx == 4'd7) begin
                     bit_idx <= '0;
                     state   <= ST_IDLE;
                  end else begin
                     bit_idx <= bit_idx + 4'd1;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   assign byte_idx = byte_q;
   assign active   = (state != ST_IDLE);
   assign tx_bit   = tx_q;

   // R2
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !slot |=> $stable(tx_bit));

   // R5
   stuff_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot && (state != ST_IDLE) && (ones == 3'(STUFF_RUN))) |=> !tx_bit);

endmodule

// File: rtl/lapd_tx_regs.sv
module lapd_tx_regs #(
   parameter int          AW        = 8,
   parameter int          BUF_BASE  = 'h86,
   parameter int          BUF_DEPTH = 88,
   parameter logic [7:0]  IE_ADDR   = 8'h04,
   parameter logic [7:0]  LEN_ADDR  = 8'h33,
   parameter logic [7:0]  CTRL_ADDR = 8'h34,
   parameter int          IDX_W     = 7,
   parameter int          LEN_W     = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             rd,
   input  logic [AW-1:0]    addr,
   input  logic [7:0]       wdata,
   output logic [7:0]       rdata,
   input  logic [IDX_W-1:0] buf_idx,
   output logic [7:0]       buf_byte,
   input  logic             accept,
   input  logic             done,
   input  logic             ser_busy,
   output logic             start_o,
   output logic [LEN_W-1:0] len_o,
   output logic             irq
);

   localparam logic [AW:0] BASE_X = (AW+1)'(BUF_BASE);
   localparam logic [AW:0] END_X  = (AW+1)'(BUF_BASE + BUF_DEPTH);

   logic [7:0]       mem [BUF_DEPTH];
   logic             bie_rx, bie_tx, bie_sec;
   logic             ie_q, status_q, start_q;
   logic [LEN_W-1:0] len_q;
   logic             busy;
   logic             in_buf;
   logic [AW:0]      off;
   logic             hit_ie, hit_len, hit_ctrl;

   always_comb begin
      in_buf   = ({1'b0, addr} >= BASE_X) && ({1'b0, addr} < END_X);
      off      = {1'b0, addr} - BASE_X;
      hit_ie   = (addr == AW'(IE_ADDR));
      hit_len  = (addr == AW'(LEN_ADDR));
      hit_ctrl = (addr == AW'(CTRL_ADDR));
      busy     = start_q | ser_busy;
   end

   always_ff @(posedge clk) begin
      if (wr && in_buf) mem[off[IDX_W-1:0]] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bie_rx   <= 1'b0;
         bie_tx   <= 1'b0;
         bie_sec  <= 1'b0;
         ie_q     <= 1'b0;
         status_q <= 1'b0;
         start_q  <= 1'b0;
         len_q    <= '0;
      end else begin
         if (wr && hit_ie) begin
            bie_rx  <= wdata[7];
            bie_tx  <= wdata[1];
            bie_sec <= wdata[0];
         end
         if (wr && hit_len) len_q <= wdata[LEN_W-1:0];
         if (wr && hit_ctrl) ie_q <= wdata[1];
         if (accept)                                 start_q <= 1'b0;
         else if (wr && hit_ctrl && wdata[3] && !busy) start_q <= 1'b1;
         if (done)                status_q <= 1'b1;
         else if (rd && hit_ctrl) status_q <= 1'b0;
      end
   end

   always_comb begin
      rdata = 8'h00;
      if (hit_ie)        rdata = {bie_rx, 5'b0, bie_tx, bie_sec};
      else if (hit_len)  rdata = 8'(len_q);
      else if (hit_ctrl) rdata = {4'b0, start_q, busy, ie_q, status_q};
      else if (in_buf)   rdata = mem[off[IDX_W-1:0]];
   end

   assign buf_byte = mem[buf_idx];
   assign start_o  = start_q;
   assign len_o    = (len_q > LEN_W'(BUF_DEPTH)) ? LEN_W'(BUF_DEPTH) : len_q;
   assign irq      = status_q & ie_q & bie_tx;

   // R10
   status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> status_q);

   // R10
   status_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && hit_ctrl && !done) |=> !status_q);

   // R7
   start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(start_q) |-> $past(accept));

   // R9
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && hit_ctrl && wdata[3] && ser_busy) |=> !start_q);

   // R8
   busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(done));

endmodule

// File: rtl/lapd_ovh_tx.sv
module lapd_ovh_tx #(
   parameter int          AW        = 8,
   parameter int          BUF_BASE  = 'h86,
   parameter int          BUF_DEPTH = 88,
   parameter logic [7:0]  IE_ADDR   = 8'h04,
   parameter logic [7:0]  LEN_ADDR  = 8'h33,
   parameter logic [7:0]  CTRL_ADDR = 8'h34
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic          reg_rd,
   input  logic [AW-1:0] reg_addr,
   input  logic [7:0]    reg_wdata,
   output logic [7:0]    reg_rdata,
   input  logic          ovh_slot,
   output logic          ovh_bit,
   output logic          irq
);

   localparam int IDX_W = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;
   localparam int LEN_W = $clog2(BUF_DEPTH + 1);

   generate
      if (BUF_DEPTH < 2 || LEN_W > 8) begin : g_bad_depth
         $error("lapd_ovh_tx: BUF_DEPTH must be 2..255");
      end
      if (BUF_BASE + BUF_DEPTH > (1 << AW)) begin : g_bad_span
         $error("lapd_ovh_tx: buffer exceeds address space");
      end
      if ((int'(IE_ADDR) >= BUF_BASE && int'(IE_ADDR) < BUF_BASE + BUF_DEPTH) ||
          (int'(LEN_ADDR) >= BUF_BASE && int'(LEN_ADDR) < BUF_BASE + BUF_DEPTH) ||
          (int'(CTRL_ADDR) >= BUF_BASE && int'(CTRL_ADDR) < BUF_BASE + BUF_DEPTH)) begin : g_bad_map
         $error("lapd_ovh_tx: control register overlaps buffer");
      end
   endgenerate

   logic [IDX_W-1:0] byte_idx;
   logic [7:0]       byte_val;
   logic [LEN_W-1:0] eff_len;
   logic             accept, done, active, start;

   lapd_tx_regs #(
      .AW(AW), .BUF_BASE(BUF_BASE), .BUF_DEPTH(BUF_DEPTH),
      .IE_ADDR(IE_ADDR), .LEN_ADDR(LEN_ADDR), .CTRL_ADDR(CTRL_ADDR),
      .IDX_W(IDX_W), .LEN_W(LEN_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr(reg_wr), .rd(reg_rd), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
      .buf_idx(byte_idx), .buf_byte(byte_val),
      .accept(accept), .done(done), .ser_busy(active),
      .start_o(start), .len_o(eff_len), .irq(irq)
   );

   lapd_tx_ser #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_ser (
      .clk(clk), .rst_n(rst_n),
      .slot(ovh_slot), .go(start), .len(eff_len), .byte_in(byte_val),
      .byte_idx(byte_idx), .accept(accept), .done(done), .active(active),
      .tx_bit(ovh_bit)
   );

endmodule

// File: tb/sim_lapd_ovh_tx.sv
module sim_lapd_ovh_tx;

   localparam int         DEPTH  = 88;
   localparam logic [7:0] A_BIE  = 8'h04;
   localparam logic [7:0] A_LEN  = 8'h33;
   localparam logic [7:0] A_CTRL = 8'h34;
   localparam logic [7:0] A_BUF  = 8'h86;
   localparam logic [7:0] FLAG   = 8'h7E;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       ovh_slot = 1'b0;
   logic       ovh_bit, irq;

   int         n_chk = 0, n_fail = 0, ph = 0;
   logic [7:0] mirror [DEPTH];

   always #5 clk = ~clk;

   lapd_ovh_tx u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ovh_slot(ovh_slot), .ovh_bit(ovh_bit), .irq(irq)
   );

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(posedge clk);
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic slot(input bit with_rd, output bit b, output logic [7:0] rv);
      @(negedge clk);
      ovh_slot = 1'b1;
      if (with_rd) begin reg_rd = 1'b1; reg_addr = A_CTRL; end
      #1 rv = reg_rdata;
      @(posedge clk);
      @(negedge clk);
      ovh_slot = 1'b0; reg_rd = 1'b0;
      #1 b = ovh_bit;
      ph = (ph + 1) % 8;
   endtask

   function automatic logic [15:0] crc_bit(input logic [15:0] c, input bit b);
      return (c[0] ^ b) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
   endfunction

   task automatic run_frame(input int len, input bit ie, input bit btx,
                            input bit poke, input bit clash);
      logic [7:0]  v, rv;
      logic [15:0] crc;
      logic        e [0:2047];
      logic        a [0:2047];
      bit          b, bb, ok;
      int          n, tail_n, eff, ones, bad;
      wr(A_BIE, {6'b0, btx, 1'b0});
      wr(A_LEN, 8'(len));
      wr(A_CTRL, {4'b0, 1'b1, 1'b0, ie, 1'b0});
      rd(A_CTRL, v);
      chk(v == {4'b0, 2'b11, ie, 1'b0}, "R7 start and busy read 1 after start", v, {4'b0, 2'b11, ie, 1'b0});
      n = 0;
      for (int i = ph; i < 8; i++) begin e[n] = FLAG[i]; n++; end
      tail_n = n;
      eff  = (len > DEPTH) ? DEPTH : len;
      crc  = 16'hFFFF;
      ones = 0;
      for (int k = 0; k < eff + 2; k++) begin
         for (int i = 0; i < 8; i++) begin
            if (k < eff) begin bb = mirror[k][i]; crc = crc_bit(crc, bb); end
            else bb = !crc[(k - eff) * 8 + i];
            e[n] = bb; n++;
            ones = bb ? ones + 1 : 0;
            if (ones == 5) begin e[n] = 1'b0; n++; ones = 0; end
         end
      end
      for (int i = 0; i < 8; i++) begin e[n] = FLAG[i]; n++; end
      bad = -1;
      rv = 8'h00;
      for (int i = 0; i < n; i++) begin
         if (poke && i == 10) wr(A_CTRL, {4'b0, 1'b1, 1'b0, ie, 1'b0});
         slot(clash && (i == n - 1), b, rv);
         a[i] = b;
         if (b !== e[i] && bad < 0) bad = i;
         if (i == tail_n - 1) begin
            rd(A_CTRL, v);
            chk(v == {5'b0, 1'b1, ie, 1'b0}, "R7 start self-clears at flag boundary", v, {5'b0, 1'b1, ie, 1'b0});
         end
         if (i == n - 2) begin
            rd(A_CTRL, v);
            chk(v[2] == 1'b1, "R8 busy held until last closing bit", v, 8'h04);
         end
      end
      if (bad < 0) chk(1'b1, "R3 R4 R5 R12 frame bits", 0, 0);
      else chk(1'b0, $sformatf("R3 R4 R5 R12 frame bit %0d of len %0d", bad, len), a[bad], e[bad]);
      if (clash)
         chk(rv[0] == 1'b0 && rv[2] == 1'b1, "R10 read in completion cycle returns old status", rv, {5'b0, 1'b1, ie, 1'b0});
      ph = 0;
      chk(irq == (ie & btx), "R11 irq gating by both enables", irq, ie & btx);
      rd(A_CTRL, v);
      chk(v == {6'b0, ie, 1'b1}, "R10 R8 status set and busy clear", v, {6'b0, ie, 1'b1});
      chk(irq == 1'b0, "R10 irq low after read", irq, 0);
      rd(A_CTRL, v);
      chk(v[0] == 1'b0, "R10 status cleared by read", v, {6'b0, ie, 1'b0});
      if (poke) begin
         ok = 1'b1;
         for (int i = 0; i < 12; i++) begin
            int p;
            p = ph;
            slot(1'b0, b, rv);
            if (b !== FLAG[p]) ok = 1'b0;
         end
         rd(A_CTRL, v);
         chk(ok && v[2] == 1'b0 && v[0] == 1'b0, "R9 start while busy ignored", v, {6'b0, ie, 1'b0});
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [7:0] v, rv;
      bit         b, ok;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      rd(A_BIE, v);  chk(v == 8'h00, "R1 block enable reset", v, 0);
      rd(A_LEN, v);  chk(v == 8'h00, "R1 length reset", v, 0);
      rd(A_CTRL, v); chk(v == 8'h00, "R1 control reset", v, 0);
      chk(irq == 1'b0, "R1 irq reset", irq, 0);

      ok = 1'b1;
      for (int i = 0; i < 16; i++) begin
         int p;
         p = ph;
         slot(1'b0, b, rv);
         if (b !== FLAG[p]) ok = 1'b0;
      end
      chk(ok, "R2 idle flags", ok, 1);

      wr(A_BIE, 8'hFF);  rd(A_BIE, v);
      chk(v == 8'h83, "R11 block enable writable bits", v, 8'h83);
      wr(A_CTRL, 8'hF7); rd(A_CTRL, v);
      chk(v == 8'h02, "R7 unused and read-only control bits", v, 8'h02);
      wr(A_LEN, 8'hFF);  rd(A_LEN, v);
      chk(v == 8'h7F, "R6 length register width", v, 8'h7F);

      for (int k = 0; k < DEPTH; k++) begin
         mirror[k] = 8'((k * 37 + 91) % 256);
         wr(A_BUF + 8'(k), mirror[k]);
      end
      rd(A_BUF, v);          chk(v == mirror[0], "R12 buffer first byte", v, mirror[0]);
      rd(A_BUF + 8'd87, v);  chk(v == mirror[87], "R12 buffer last byte", v, mirror[87]);

      for (int len = 0; len < 8; len++) begin
         for (int i = 0; i < (len % 3) + 1; i++) slot(1'b0, b, rv);
         run_frame(len, len[0], len[1], 1'b0, 1'b0);
      end

      for (int k = 0; k < 4; k++) begin mirror[k] = 8'hFF; wr(A_BUF + 8'(k), 8'hFF); end
      slot(1'b0, b, rv);
      run_frame(4, 1'b1, 1'b1, 1'b0, 1'b0);

      run_frame(5, 1'b1, 1'b1, 1'b1, 1'b0);

      slot(1'b0, b, rv); slot(1'b0, b, rv);
      run_frame(2, 1'b1, 1'b1, 1'b0, 1'b1);

      run_frame(127, 1'b0, 1'b1, 1'b0, 1'b0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule